// File: doc/BRIEF.md
# Serial EEPROM Programming Controller

This block lets a host reach a serial EEPROM through a handful of byte-wide registers. Software loads a 9-bit word address and a 16-bit data word into the registers. It then writes a command byte that holds an opcode and a go bit. The controller turns the command into one transaction on a memory port and holds a busy indication until that transaction is finished. For a read, it places the returned word back into the two data registers.

The host interface is a plain register port. Writes are strobed and reads are combinational. The port responds only while the system-level configuration state is active, which is signalled by `cfg_active`. The memory side is a request/response pair. A request is offered with `mem_req_valid`, and it is taken on the first clock edge at which `mem_req_ready` is also high. Until that edge the request may be held off for any number of cycles, and during that time valid, write flag, address and data stay frozen. A read response has no ready signal. The controller accepts `mem_rsp_valid` in the cycle it arrives, because it waits for that response and for nothing else. A write finishes after a fixed, parameterised number of cycles counted from its handshake, which stands in for the EEPROM's internal programming time of roughly ten milliseconds.

Top module: `eepc_ctrl`

## Requirements
- R1: After reset the command, address and both data registers read 0x00, the status register reads 0x01 (done), and `mem_req_valid` is low.
- R2: The register offsets are as follows. Offset 0xF0 is the command register: bits 1:0 are the opcode (01 write, 10 read), bit 2 is the go bit and bit 7 is address bit 8. Offset 0xF1 holds address bits 7:0, 0xF2 holds the upper data byte and 0xF3 holds the lower data byte. Offset 0x05 is status, with bit 0 equal to 1 when done and 0 when busy. Command bits 6:3 always read as 0, whatever was written to them.
- R3: While `cfg_active` is low, register writes have no effect and every register read returns 0x00.
- R4: An operation starts only from a command write with the go bit at 1. Writing an opcode with go at 0 produces no memory request.
- R5: Status reads busy from the cycle after the go write until the operation completes. At completion the go bit clears itself and status reads done.
- R6: A write operation makes exactly one request, with the write flag at 1, address {cmd bit 7, 0xF1} and data {0xF2, 0xF3}. Status returns to done exactly WRITE_CYCLES cycles after the request handshake.
- R7: A read operation makes one request with the write flag at 0. The response word is loaded into 0xF2 (upper byte) and 0xF3 (lower byte) on the same edge that status becomes done.
- R8: With the go bit set, opcodes 00 and 11 complete after a single busy cycle and issue no memory request.
- R9: Register writes that arrive while the block is busy are ignored. This covers the command, address and data registers.
- R10: Once `mem_req_valid` is high, it stays high with stable write flag, address and data until `mem_req_ready` is sampled high. Each operation hands over exactly one request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_active | input | 1 | High while the configuration state is active; gates register access |
| reg_addr | input | 8 | Register offset for reads and writes |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 9 | Word address |
| mem_req_wdata | output | 16 | Word to write |
| mem_rsp_valid | input | 1 | Read word is present |
| mem_rsp_data | input | 16 | Read word |

## Verification
The hardest case to reach is a host write that arrives during the short time an operation is actually in flight, or a reset that lands in that time. The bench therefore shrinks the write delay to a dozen cycles. It starts a write and then issues address, data and command writes in the following cycles. It also asserts reset partway through a write. Back-pressure comes from a memory model that raises ready only one cycle in three for selected vectors. This keeps a request waiting across several edges while the bench checks that each operation still hands over exactly one request.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int MADDR_W = BYTE_W + 1;

  localparam logic [BYTE_W-1:0] OFS_CMD = 8'hF0;
  localparam logic [BYTE_W-1:0] OFS_ADR = 8'hF1;
  localparam logic [BYTE_W-1:0] OFS_DHI = 8'hF2;
  localparam logic [BYTE_W-1:0] OFS_DLO = 8'hF3;

  localparam int CMD_GO_BIT = 2;
  localparam int CMD_A8_BIT = 7;

  typedef enum logic [1:0] {
    OP_NOP     = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_INVALID = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_WAIT
  } seq_st_e;
endpackage

// File: rtl/eepc_regs.sv
module eepc_regs
  import eepc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STAT_OFS = 8'h05
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_active,
  input  logic [BYTE_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [BYTE_W-1:0]  reg_wdata,
  output logic [BYTE_W-1:0]  reg_rdata,
  input  logic               done_i,
  input  logic               load_i,
  input  logic [WORD_W-1:0]  load_word_i,
  output logic               go_o,
  output op_e                op_o,
  output logic [MADDR_W-1:0] maddr_o,
  output logic [WORD_W-1:0]  word_o
);
  logic [1:0]        op_q;
  logic              go_q;
  logic              a8_q;
  logic [BYTE_W-1:0] adr_q;
  logic [BYTE_W-1:0] dhi_q;
  logic [BYTE_W-1:0] dlo_q;
  logic              wr_ok;

  // host writes land only when the configuration state is on and nothing runs
  assign wr_ok = reg_wr && cfg_active && !go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      go_q  <= 1'b0;
      a8_q  <= 1'b0;
      adr_q <= '0;
      dhi_q <= '0;
      dlo_q <= '0;
    end else begin
      if (done_i) go_q <= 1'b0;
      if (load_i) begin
        dhi_q <= load_word_i[WORD_W-1:BYTE_W];
        dlo_q <= load_word_i[BYTE_W-1:0];
      end
      if (wr_ok) begin
        case (reg_addr)
          OFS_CMD: begin
            op_q <= reg_wdata[1:0];
            go_q <= reg_wdata[CMD_GO_BIT];
            a8_q <= reg_wdata[CMD_A8_BIT];
          end
          OFS_ADR: adr_q <= reg_wdata;
          OFS_DHI: dhi_q <= reg_wdata;
          OFS_DLO: dlo_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (cfg_active) begin
      case (reg_addr)
        OFS_CMD:  reg_rdata = {a8_q, 4'b0000, go_q, op_q};
        OFS_ADR:  reg_rdata = adr_q;
        OFS_DHI:  reg_rdata = dhi_q;
        OFS_DLO:  reg_rdata = dlo_q;
        STAT_OFS: reg_rdata = {{(BYTE_W-1){1'b0}}, !go_q};
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign go_o    = go_q;
  assign op_o    = op_e'(op_q);
  assign maddr_o = {a8_q, adr_q};
  assign word_o  = {dhi_q, dlo_q};
endmodule

// File: rtl/eepc_seq.sv
module eepc_seq
  import eepc_pkg::*;
#(
  parameter int WRITE_CYCLES = 143180
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  op_e                op_i,
  input  logic [MADDR_W-1:0] maddr_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [MADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [WORD_W-1:0]  mem_rsp_data,
  output logic               done_o,
  output logic               load_o,
  output logic [WORD_W-1:0]  load_word_o
);
  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYCLES - 1);

  seq_st_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    done_o  = 1'b0;
    load_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go_i) begin
          if (op_i == OP_WRITE || op_i == OP_READ) state_d = ST_REQ;
          else                                     done_o  = 1'b1;
        end
      end
      ST_REQ: begin
        if (mem_req_ready) state_d = (op_i == OP_READ) ? ST_RSP : ST_WAIT;
      end
      ST_RSP: begin
        if (mem_rsp_valid) begin
          load_o  = 1'b1;
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (cnt_q == CNT_LAST) begin
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAIT) cnt_q <= cnt_q + 1'b1;
      else                    cnt_q <= '0;
    end
  end

  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_write = (op_i == OP_WRITE);
  assign mem_req_addr  = maddr_i;
  assign mem_req_wdata = word_i;
  assign load_word_o   = mem_rsp_data;
endmodule

// File: rtl/eepc_ctrl.sv
module eepc_ctrl
  import eepc_pkg::*;
#(
  parameter int                WRITE_CYCLES = 143180,
  parameter logic [BYTE_W-1:0] STAT_OFS     = 8'h05
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_active,
  input  logic [BYTE_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [BYTE_W-1:0]  reg_wdata,
  output logic [BYTE_W-1:0]  reg_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [MADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [WORD_W-1:0]  mem_rsp_data
);
  logic               go;
  op_e                op;
  logic [MADDR_W-1:0] maddr;
  logic [WORD_W-1:0]  word;
  logic               done;
  logic               load;
  logic [WORD_W-1:0]  load_word;

  eepc_regs #(.STAT_OFS(STAT_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .done_i(done), .load_i(load),
    .load_word_i(load_word), .go_o(go), .op_o(op),
    .maddr_o(maddr), .word_o(word)
  );

  eepc_seq #(.WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_i(go), .op_i(op),
    .maddr_i(maddr), .word_i(word),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done_o(done), .load_o(load),
    .load_word_o(load_word)
  );
endmodule

// File: rtl/eepc_chk.sv
module eepc_chk
  import eepc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_active,
  input logic               go,
  input op_e                op,
  input logic [MADDR_W-1:0] maddr,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic               mem_req_write,
  input logic [MADDR_W-1:0] mem_req_addr,
  input logic [WORD_W-1:0]  mem_req_wdata
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_wdata) && $stable(mem_req_write));

  // R5
  no_req_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !mem_req_valid);

  // R8
  bad_op_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go) && (op == OP_NOP || op == OP_INVALID) |=> !go);

  // R9
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> $stable(maddr));

  // R6
  write_still_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_req_write |=> go);

  // R3
  cfg_off_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active |=> $stable(maddr));
endmodule

bind eepc_ctrl eepc_chk u_eepc_chk (
  .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .go(go), .op(op),
  .maddr(maddr), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata)
);

// File: tb/test_eepc_ctrl.sv
module test_eepc_ctrl;
  localparam int W = 12;
  localparam logic [7:0] STAT = 8'h05;
  localparam logic [24:0] VEC [4] = '{25'h000A55A, 25'h1FF0001, 25'h100FFFF, 25'h0C31234};

  logic clk = 0, rst_n = 0, cfg_active = 1;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic reg_wr = 0;
  logic mem_req_valid, mem_req_ready = 1, mem_req_write;
  logic [8:0] mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic mem_rsp_valid = 0;
  logic [15:0] mem_rsp_data = 0;

  int checks = 0, errors = 0, cyc = 0, req_cnt = 0, hs_cyc = 0, stall_ph = 0;
  bit stall_en = 0, finished = 0;
  logic seen_v = 0, seen_w = 0, last_wr = 0;
  logic [8:0] seen_a = 0, last_addr = 0;
  logic [15:0] seen_d = 0, last_data = 0;
  logic [15:0] mem_m [512];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eepc_ctrl #(.WRITE_CYCLES(W)) i_eepc_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // memory model: acts at falling edges on what the previous rising edge accepted
  always @(negedge clk) begin
    mem_rsp_valid = 0;
    if (rst_n && seen_v && mem_req_ready) begin
      req_cnt++;
      hs_cyc = cyc;
      last_addr = seen_a; last_wr = seen_w; last_data = seen_d;
      if (seen_w) mem_m[seen_a] = seen_d;
      else begin
        mem_rsp_valid = 1;
        mem_rsp_data = mem_m[seen_a];
      end
    end
    seen_v = rst_n && mem_req_valid;
    seen_a = mem_req_addr; seen_w = mem_req_write; seen_d = mem_req_wdata;
    stall_ph++;
    mem_req_ready = !stall_en || (stall_ph % 3 == 0);
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(output int at);
    logic [7:0] v;
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      reg_read(STAT, v);
      if (v[0]) begin at = cyc; return; end
      @(negedge clk);
    end
  endtask

  task automatic do_write(logic [8:0] a, logic [15:0] w);
    logic [7:0] v; int at, n0;
    n0 = req_cnt;
    reg_write(8'hF1, a[7:0]);
    reg_write(8'hF2, w[15:8]);
    reg_write(8'hF3, w[7:0]);
    reg_write(8'hF0, {a[8], 4'b0000, 1'b1, 2'b01});
    reg_read(STAT, v);
    chk("R5", "busy after go", {31'b0, v[0]}, 0);
    wait_done(at);
    chk("R6", "write duration", at - hs_cyc, W);
    chk("R6", "write fields", {last_wr, last_addr, last_data}, {1'b1, a, w});
    chk("R10", "one request", req_cnt - n0, 1);
    reg_read(8'hF0, v);
    chk("R5", "go self-clear", v, {a[8], 4'b0000, 1'b0, 2'b01});
  endtask

  task automatic do_read(logic [8:0] a, logic [15:0] w);
    logic [7:0] hi, lo; int at;
    reg_write(8'hF1, a[7:0]);
    reg_write(8'hF2, ~w[15:8]);
    reg_write(8'hF3, ~w[7:0]);
    reg_write(8'hF0, {a[8], 4'b0000, 1'b1, 2'b10});
    wait_done(at);
    reg_read(8'hF2, hi);
    reg_read(8'hF3, lo);
    chk("R7", "read word", {hi, lo}, w);
    chk("R7", "read request", {last_wr, last_addr}, {1'b0, a});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n0, at;
    for (int i = 0; i < 512; i++) mem_m[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    reg_read(STAT, v); chk("R1", "status", v, 8'h01);
    reg_read(8'hF0, v); chk("R1", "cmd", v, 8'h00);
    reg_read(8'hF3, v); chk("R1", "data lo", v, 8'h00);
    chk("R1", "no request", mem_req_valid, 0);

    // vector table: write then read back, back-pressure on odd entries (R10)
    for (int k = 0; k < 4; k++) begin
      stall_en = k[0];
      do_write(VEC[k][24:16], VEC[k][15:0]);
      do_read(VEC[k][24:16], VEC[k][15:0]);
    end
    stall_en = 0;

    // R2 reserved bits read as zero
    reg_write(8'hF0, 8'hF9);
    reg_read(8'hF0, v); chk("R2", "reserved bits", v, 8'h81);

    // R4 opcode without go
    n0 = req_cnt;
    reg_write(8'hF0, 8'h01);
    repeat (20) @(negedge clk);
    chk("R4", "no request", req_cnt - n0, 0);
    reg_read(STAT, v); chk("R4", "still done", v, 8'h01);

    // R8 bad opcodes
    for (int op = 0; op < 4; op += 3) begin
      n0 = req_cnt;
      reg_write(8'hF0, {5'b00000, 1'b1, op[1:0]});
      reg_read(STAT, v); chk("R8", "one busy cycle", v, 8'h00);
      @(negedge clk);
      reg_read(STAT, v); chk("R8", "done next cycle", v, 8'h01);
      repeat (3) @(negedge clk);
      chk("R8", "no request", req_cnt - n0, 0);
    end

    // R9 writes while busy are ignored
    reg_write(8'hF1, 8'hAA);
    reg_write(8'hF2, 8'h13);
    reg_write(8'hF3, 8'h57);
    reg_write(8'hF0, 8'h05);
    reg_write(8'hF1, 8'h55);
    reg_write(8'hF2, 8'h99);
    reg_write(8'hF0, 8'h00);
    wait_done(at);
    reg_read(8'hF1, v); chk("R9", "addr kept", v, 8'hAA);
    reg_read(8'hF2, v); chk("R9", "data kept", v, 8'h13);
    chk("R9", "written word", {last_addr, last_data}, {9'h0AA, 16'h1357});

    // R3 configuration state gating
    cfg_active = 0;
    reg_read(8'hF1, v); chk("R3", "read zero", v, 8'h00);
    reg_read(STAT, v); chk("R3", "status zero", v, 8'h00);
    n0 = req_cnt;
    reg_write(8'hF1, 8'h77);
    reg_write(8'hF0, 8'h05);
    repeat (5) @(negedge clk);
    cfg_active = 1;
    reg_read(8'hF1, v); chk("R3", "write ignored", v, 8'hAA);
    chk("R3", "no request", req_cnt - n0, 0);

    // R1 reset in the middle of a write
    reg_write(8'hF0, 8'h05);
    repeat (4) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    reg_read(STAT, v); chk("R1", "status after reset", v, 8'h01);
    reg_read(8'hF1, v); chk("R1", "addr after reset", v, 8'h00);
    chk("R1", "request dropped", mem_req_valid, 0);
    rst_n = 1;
    @(negedge clk);
    do_write(9'h042, 16'hBEEF);
    do_read(9'h042, 16'hBEEF);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule